// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block brings an SDRAM device from power-up to normal service. Software, or a boot engine, first latches a refresh prescale value and a refresh interval value. It then selects one special operation at a time on a 2-bit operation selector and makes an access, signalled by a one-cycle trigger. Each accepted access puts exactly one SDRAM command on the command/address outputs in place of a data transfer.

The block enforces the only legal order. It accepts one precharge of all banks, then a fixed number of auto (CBR) refreshes, then one mode register write. After that, a normal-mode access with refresh enabled hands the device over to normal operation. Any trigger that does not match the next step is dropped. So is any trigger that arrives too early after the previous command. A trigger sent before the timer values are loaded is also dropped.

Once the device is in service, a `ready` output stays high. A two-stage refresh timer then raises a one-cycle refresh request at a fixed period. Reset restarts everything, including the need to reload the timer values.

Top module: `sdinit_seq`

## Requirements
- R1: While and right after reset, `sdCmd` is NOP (4'b0111), `ready` is 0 and `refreshReq` is 0.
- R2: Triggers are ignored (`sdCmd` stays NOP) until `loadTimers` has been pulsed since the last reset.
- R3: The first accepted command is precharge-all: `sdCmd` = 4'b0010 with `sdAddr` equal to 1 << PALL_BIT (bit 10 by default) and all other address bits 0.
- R4: A trigger whose `opMode` (0 normal, 1 precharge, 2 refresh, 3 mode write) does not select the next command in the order is ignored: no command is issued and `ready` does not change.
- R5: Exactly CBR_COUNT (8) refresh commands (`sdCmd` = 4'b0001) are accepted after the precharge; a further refresh trigger is ignored.
- R6: After the last refresh, a mode-write trigger issues `sdCmd` = 4'b0000 with `sdAddr` equal to `mrsValue`.
- R7: After an accepted command, triggers are ignored for T-1 cycles, where T is T_RP after precharge, T_RFC after a refresh and T_MRD after the mode write. A trigger exactly T cycles after the command is accepted.
- R8: `ready` rises only on a normal-mode trigger with `refreshEn` = 1 that comes after the mode write's wait; with `refreshEn` = 0 the trigger is ignored. Once high, `ready` stays high until reset.
- R9: `refreshReq` is 0 until `ready` is 1. It then pulses for one cycle every (P+1)*(N+1) cycles, the first pulse coming (P+1)*(N+1) cycles after `ready` rises (P = prescale, N = interval).
- R10: An issued command is on `sdCmd` for exactly one cycle, the cycle after the accepting clock edge; in every other cycle `sdCmd` is NOP.
- R11: A reset in the middle of the sequence restarts it: after reload, a refresh trigger is ignored and precharge is accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadTimers | input | 1 | Latches prescVal and intervalVal |
| prescVal | input | PRESC_W | Refresh prescale value P |
| intervalVal | input | INTV_W | Refresh interval value N |
| mrsValue | input | ADDR_W | Address word driven with the mode write |
| opMode | input | 2 | Operation selector: 0 normal, 1 precharge, 2 refresh, 3 mode write |
| refreshEn | input | 1 | Refresh enable, needed for the hand-over to normal mode |
| trigger | input | 1 | One-cycle access strobe |
| sdCmd | output | 4 | {csN, rasN, casN, weN} |
| sdAddr | output | ADDR_W | SDRAM address bus |
| ready | output | 1 | Device in normal operation with refresh |
| refreshReq | output | 1 | One-cycle periodic refresh request |

## Verification
A trigger sampled at a clock edge drives its command on `sdCmd` from that same edge, so the bench checks `sdCmd`, `sdAddr` and `ready` at the falling edge right after the edge that took the trigger. Wait windows are counted in edges from the accepting edge: probes at offsets 1 to T-1 must show NOP, and the probe at offset T must show the command. `refreshReq` is checked at every falling edge after `ready` rises, and a pulse is expected only at multiples of (P+1)*(N+1) edges. The whole sequence is swept over several prescale/interval pairs and mode-write values.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

  typedef enum logic [1:0] {
    OP_NORMAL    = 2'd0,
    OP_PRECHARGE = 2'd1,
    OP_REFRESH   = 2'd2,
    OP_MODEWR    = 2'd3
  } opSel_t;

  typedef enum logic [2:0] {
    ST_PRE,
    ST_CBR,
    ST_MRS,
    ST_NORM,
    ST_RUN
  } step_t;

  // strobes from control to datapath
  typedef struct packed {
    logic issuePre;
    logic issueCbr;
    logic issueMrs;
    logic enterRun;
  } strobe_t;

  // {csN, rasN, casN, weN}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_MRS = 4'b0000;

endpackage

// File: rtl/sdinit_ctrl.sv
module sdinit_ctrl
  import sdinit_pkg::*;
#(
  parameter int CBR_COUNT = 8,
  parameter int T_RP      = 3,
  parameter int T_RFC     = 5,
  parameter int T_MRD     = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    trigger,
  input  logic [1:0] opMode,
  input  logic    refreshEn,
  input  logic    timersLoaded,
  output strobe_t strobes,
  output logic    ready
);

  localparam int MAX_T  = (T_RP > T_RFC) ? ((T_RP > T_MRD) ? T_RP : T_MRD)
                                         : ((T_RFC > T_MRD) ? T_RFC : T_MRD);
  localparam int MIN_T  = (T_RP < T_RFC) ? ((T_RP < T_MRD) ? T_RP : T_MRD)
                                         : ((T_RFC < T_MRD) ? T_RFC : T_MRD);
  localparam int WAIT_W = $clog2(MAX_T + 1);
  localparam int CNT_W  = $clog2(CBR_COUNT + 1);
  localparam logic [WAIT_W-1:0] RP_LOAD  = WAIT_W'(T_RP - 1);
  localparam logic [WAIT_W-1:0] RFC_LOAD = WAIT_W'(T_RFC - 1);
  localparam logic [WAIT_W-1:0] MRD_LOAD = WAIT_W'(T_MRD - 1);
  localparam logic [CNT_W-1:0]  CBR_LAST = CNT_W'(CBR_COUNT - 1);

  step_t            step;
  logic [CNT_W-1:0] cbrCnt;
  logic [WAIT_W-1:0] waitCnt;
  logic             canIssue;
  opSel_t           opSel;

  assign opSel    = opSel_t'(opMode);
  assign canIssue = trigger && timersLoaded && (waitCnt == '0);

  always_comb begin
    strobes = '0;
    unique case (step)
      ST_PRE:  strobes.issuePre = canIssue && (opSel == OP_PRECHARGE);
      ST_CBR:  strobes.issueCbr = canIssue && (opSel == OP_REFRESH);
      ST_MRS:  strobes.issueMrs = canIssue && (opSel == OP_MODEWR);
      ST_NORM: strobes.enterRun = canIssue && (opSel == OP_NORMAL) && refreshEn;
      default: strobes = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      step    <= ST_PRE;
      cbrCnt  <= '0;
      waitCnt <= '0;
    end else begin
      if (waitCnt != '0) waitCnt <= waitCnt - 1'b1;
      if (strobes.issuePre) begin
        step    <= ST_CBR;
        waitCnt <= RP_LOAD;
      end
      if (strobes.issueCbr) begin
        cbrCnt  <= cbrCnt + 1'b1;
        waitCnt <= RFC_LOAD;
        if (cbrCnt == CBR_LAST) step <= ST_MRS;
      end
      if (strobes.issueMrs) begin
        step    <= ST_NORM;
        waitCnt <= MRD_LOAD;
      end
      if (strobes.enterRun) step <= ST_RUN;
    end
  end

  assign ready = (step == ST_RUN);

  // R5
  cbr_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cbrCnt <= CNT_W'(CBR_COUNT));

  // R4
  step_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (step == ST_CBR) |=> (step == ST_CBR || step == ST_MRS));

  // R8
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> ready);

  // R7
  generate
    if (MIN_T > 1) begin : g_spacing
      cmd_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
        (strobes.issuePre || strobes.issueCbr || strobes.issueMrs)
        |=> !(strobes.issuePre || strobes.issueCbr || strobes.issueMrs || strobes.enterRun));
    end
  endgenerate

endmodule

// File: rtl/sdinit_cmdpath.sv
module sdinit_cmdpath
  import sdinit_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int PALL_BIT = 10,
  parameter int PRESC_W  = 8,
  parameter int INTV_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobes,
  input  logic               loadTimers,
  input  logic [PRESC_W-1:0] prescVal,
  input  logic [INTV_W-1:0]  intervalVal,
  input  logic [ADDR_W-1:0]  mrsValue,
  output logic               timersLoaded,
  output logic [PRESC_W-1:0] prescReg,
  output logic [INTV_W-1:0]  intvReg,
  output logic [3:0]         sdCmd,
  output logic [ADDR_W-1:0]  sdAddr
);

  localparam logic [ADDR_W-1:0] PALL_ADDR = ADDR_W'(1) << PALL_BIT;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timersLoaded <= 1'b0;
      prescReg     <= '0;
      intvReg      <= '0;
    end else if (loadTimers) begin
      timersLoaded <= 1'b1;
      prescReg     <= prescVal;
      intvReg      <= intervalVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sdCmd  <= CMD_NOP;
      sdAddr <= '0;
    end else begin
      sdCmd  <= CMD_NOP;
      sdAddr <= '0;
      if (strobes.issuePre) begin
        sdCmd  <= CMD_PRE;
        sdAddr <= PALL_ADDR;
      end else if (strobes.issueCbr) begin
        sdCmd  <= CMD_REF;
      end else if (strobes.issueMrs) begin
        sdCmd  <= CMD_MRS;
        sdAddr <= mrsValue;
      end
    end
  end

  // R2
  load_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.issuePre || strobes.issueCbr || strobes.issueMrs) |-> timersLoaded);

  // R10
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes));

endmodule

// File: rtl/sdinit_reftimer.sv
module sdinit_reftimer #(
  parameter int PRESC_W = 8,
  parameter int INTV_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               run,
  input  logic [PRESC_W-1:0] prescVal,
  input  logic [INTV_W-1:0]  intervalVal,
  output logic               refreshReq
);

  logic [PRESC_W-1:0] preCnt;
  logic [INTV_W-1:0]  intCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt     <= '0;
      intCnt     <= '0;
      refreshReq <= 1'b0;
    end else begin
      refreshReq <= 1'b0;
      if (start) begin
        preCnt <= prescVal;
        intCnt <= intervalVal;
      end else if (run) begin
        if (preCnt == '0) begin
          preCnt <= prescVal;
          if (intCnt == '0) begin
            intCnt     <= intervalVal;
            refreshReq <= 1'b1;
          end else begin
            intCnt <= intCnt - 1'b1;
          end
        end else begin
          preCnt <= preCnt - 1'b1;
        end
      end
    end
  end

  // R9
  refresh_after_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    refreshReq |-> run);

endmodule

// File: rtl/sdinit_seq.sv
module sdinit_seq
  import sdinit_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int PALL_BIT  = 10,
  parameter int PRESC_W   = 8,
  parameter int INTV_W    = 8,
  parameter int CBR_COUNT = 8,
  parameter int T_RP      = 3,
  parameter int T_RFC     = 5,
  parameter int T_MRD     = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               loadTimers,
  input  logic [PRESC_W-1:0] prescVal,
  input  logic [INTV_W-1:0]  intervalVal,
  input  logic [ADDR_W-1:0]  mrsValue,
  input  logic [1:0]         opMode,
  input  logic               refreshEn,
  input  logic               trigger,
  output logic [3:0]         sdCmd,
  output logic [ADDR_W-1:0]  sdAddr,
  output logic               ready,
  output logic               refreshReq
);

  strobe_t            strobes;
  logic               timersLoaded;
  logic [PRESC_W-1:0] prescReg;
  logic [INTV_W-1:0]  intvReg;

  sdinit_ctrl #(
    .CBR_COUNT(CBR_COUNT), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .trigger(trigger), .opMode(opMode),
    .refreshEn(refreshEn), .timersLoaded(timersLoaded),
    .strobes(strobes), .ready(ready)
  );

  sdinit_cmdpath #(
    .ADDR_W(ADDR_W), .PALL_BIT(PALL_BIT), .PRESC_W(PRESC_W), .INTV_W(INTV_W)
  ) path_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .loadTimers(loadTimers),
    .prescVal(prescVal), .intervalVal(intervalVal), .mrsValue(mrsValue),
    .timersLoaded(timersLoaded), .prescReg(prescReg), .intvReg(intvReg),
    .sdCmd(sdCmd), .sdAddr(sdAddr)
  );

  sdinit_reftimer #(
    .PRESC_W(PRESC_W), .INTV_W(INTV_W)
  ) timer_i (
    .clk(clk), .rstN(rstN), .start(strobes.enterRun), .run(ready),
    .prescVal(prescReg), .intervalVal(intvReg), .refreshReq(refreshReq)
  );

endmodule

// File: tb/sdinit_seq_tb.sv
`timescale 1ns/1ps
module sdinit_seq_tb_top;

  localparam int ADDR_W = 13;
  localparam int PALL_BIT = 10;
  localparam int T_RP = 3;
  localparam int T_RFC = 5;
  localparam int T_MRD = 2;
  localparam int NCBR = 8;
  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;
  localparam logic [1:0] M_NORM = 2'd0, M_PRE = 2'd1, M_REF = 2'd2, M_MRS = 2'd3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loadTimers = 1'b0;
  logic [7:0] prescVal = '0;
  logic [7:0] intervalVal = '0;
  logic [ADDR_W-1:0] mrsValue = '0;
  logic [1:0] opMode = '0;
  logic refreshEn = 1'b0;
  logic trigger = 1'b0;
  logic [3:0] sdCmd;
  logic [ADDR_W-1:0] sdAddr;
  logic ready, refreshReq;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  sdinit_seq dut_i (
    .clk(clk), .rstN(rstN), .loadTimers(loadTimers), .prescVal(prescVal),
    .intervalVal(intervalVal), .mrsValue(mrsValue), .opMode(opMode),
    .refreshEn(refreshEn), .trigger(trigger), .sdCmd(sdCmd), .sdAddr(sdAddr),
    .ready(ready), .refreshReq(refreshReq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a falling edge; uses exactly one rising edge
  task automatic tryCmd(input logic [1:0] m, input logic en, input logic [3:0] expCmd,
                        input string tag);
    opMode = m; refreshEn = en; trigger = 1'b1;
    @(posedge clk); @(negedge clk);
    trigger = 1'b0;
    chk(tag, {28'd0, sdCmd}, {28'd0, expCmd});
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) begin @(posedge clk); @(negedge clk); end
    chk("R1 cmd", {28'd0, sdCmd}, {28'd0, NOP});
    chk("R1 ready", {31'd0, ready}, 32'd0);
    chk("R1 refreshReq", {31'd0, refreshReq}, 32'd0);
    rstN = 1'b1;
  endtask

  task automatic doLoad(input int p, input int n);
    prescVal = 8'(p); intervalVal = 8'(n); loadTimers = 1'b1;
    @(posedge clk); @(negedge clk);
    loadTimers = 1'b0;
  endtask

  task automatic runConfig(input int p, input int n, input logic [ADDR_W-1:0] mv, input bit midReset);
    int d;
    d = (p + 1) * (n + 1);
    mrsValue = mv;
    doReset();
    tryCmd(M_PRE, 1'b0, NOP, "R2 precharge before load");
    doLoad(p, n);
    if (midReset) begin
      tryCmd(M_PRE, 1'b0, PRE, "R3 precharge");
      for (int t = 1; t < T_RP; t++) tryCmd(M_REF, 1'b0, NOP, "R7 rp window");
      for (int j = 0; j < 3; j++) begin
        tryCmd(M_REF, 1'b0, REF, "R5 refresh");
        for (int t = 1; t < T_RFC; t++) tryCmd(M_REF, 1'b0, NOP, "R7 rfc window");
      end
      doReset();
      doLoad(p, n);
      tryCmd(M_REF, 1'b0, NOP, "R11 refresh after restart");
    end
    tryCmd(M_REF, 1'b0, NOP, "R4 refresh first");
    tryCmd(M_MRS, 1'b0, NOP, "R4 mode write first");
    tryCmd(M_NORM, 1'b1, NOP, "R4 normal first");
    chk("R8 ready before sequence", {31'd0, ready}, 32'd0);
    tryCmd(M_PRE, 1'b0, PRE, "R3 precharge");
    chk("R3 address", {19'd0, sdAddr}, 32'd1 << PALL_BIT);
    for (int t = 1; t < T_RP; t++) tryCmd(M_REF, 1'b0, NOP, "R7 rp window");
    for (int j = 0; j < NCBR; j++) begin
      tryCmd(M_REF, 1'b0, REF, "R5 refresh");
      for (int t = 1; t < T_RFC; t++) tryCmd(M_REF, 1'b0, NOP, "R10 rfc window nop");
      if (j == 3) begin
        tryCmd(M_PRE, 1'b0, NOP, "R4 second precharge");
        tryCmd(M_MRS, 1'b0, NOP, "R4 early mode write");
      end
    end
    tryCmd(M_PRE, 1'b0, NOP, "R4 precharge after refreshes");
    tryCmd(M_REF, 1'b0, NOP, "R5 extra refresh");
    tryCmd(M_MRS, 1'b0, MRS, "R6 mode write");
    chk("R6 address", {19'd0, sdAddr}, {19'd0, mv});
    for (int t = 1; t < T_MRD; t++) begin
      tryCmd(M_NORM, 1'b1, NOP, "R7 mrd window");
      chk("R7 ready in mrd window", {31'd0, ready}, 32'd0);
    end
    tryCmd(M_NORM, 1'b0, NOP, "R8 normal without refresh");
    chk("R8 ready without refresh", {31'd0, ready}, 32'd0);
    chk("R9 no request before ready", {31'd0, refreshReq}, 32'd0);
    tryCmd(M_NORM, 1'b1, NOP, "R8 normal with refresh");
    chk("R8 ready", {31'd0, ready}, 32'd1);
    for (int i = 1; i <= 3 * d; i++) begin
      @(posedge clk); @(negedge clk);
      chk("R9 refresh request", {31'd0, refreshReq}, {31'd0, (i % d) == 0});
    end
    chk("R8 ready held", {31'd0, ready}, 32'd1);
  endtask

  initial begin
    @(negedge clk);
    runConfig(1, 1, 13'h0032, 1'b1);
    runConfig(3, 2, 13'h0127, 1'b0);
    runConfig(0, 3, 13'h1fff, 1'b0);
    runConfig(2, 0, 13'h0000, 1'b0);
    runConfig(4, 1, 13'h0a5a, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule